// File: doc/BRIEF.md
# Interval Down-Counter Timer with Register Bus

This block is a programmable down-counting timer that sits on a simple word-addressed register bus. Software writes a reload value, then uses control bits to start or stop the count and to pick periodic or single-shot behaviour. While it runs, the count drops by one on every clock. When the count runs out, the block sets a timeout flag. A level interrupt output follows that flag, gated by an enable bit.

Each bus access is one request cycle. The block answers with an acknowledge and, for reads, the data in the next cycle. Only full-word accesses exist. The two lowest byte-address bits are ignored. The count can be read back live at any time without disturbing it.

Top module: `intv_timer`

## Requirements
- R1: Register byte offsets are 0x0 status, 0x4 control, 0x8 reload and 0xC live count, and addr_i[1:0] is ignored. Every request cycle gives ack_o high in the next cycle. For a read, rdata_o carries the register value as it stood at the request edge. In every other cycle rdata_o is zero.
- R2: Status bit 0 is the timeout flag and bit 1 is the running indicator. All other status bits read zero.
- R3: Control bit 0 is interrupt enable, bit 1 is continuous mode, bit 2 is start and bit 3 is stop. A control write stores the whole 32-bit word, and a read returns it unchanged.
- R4: A control write with bit 2 set starts the counter and one with bit 3 set halts it. When both bits are set, the counter halts.
- R5: Any write to status clears the timeout flag, whatever the data. If an expiry happens on the same edge, the flag ends up set.
- R6: A write to the reload register stores the value and loads it into the counter on the same edge. It replaces whatever the count would otherwise have become.
- R7: While running, the count drops by one per clock. Expiry happens on the edge where a running count is 1 or 0, so a counter started at zero expires one cycle later.
- R8: On expiry in single-shot mode (control bit 1 clear), the flag sets, the count stays at zero and the running bit clears.
- R9: On expiry in continuous mode, the flag sets and the counter reloads from the reload register and keeps running.
- R10: irq_o is high exactly when the timeout flag and the interrupt-enable bit are both set.
- R11: Reading offset 0xC returns the live count. Writes to 0xC change nothing.
- R12: Offsets at or above 0x10 read as zero, and writes to them change no register.
- R13: Reset, whether at start-up or in mid-run, clears every register and the count, and leaves the counter stopped with irq_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| ack_o | output | 1 | Access acknowledge, one cycle after request |
| rdata_o | output | DATA_W | Read data, valid with ack_o |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: a 32-bit data path and a 5-bit byte address. The 5-bit address puts the unmapped window at 0x10 to 0x1C within reach of the undefined-offset checks. Reload values stay small (0 to 7), so single-shot expiry, continuous reload, the start-from-zero case and an expiry landing on the same edge as a status write all occur within a few cycles. The full 32-bit word width is exercised through control read-back with high bits set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ST_TO_BIT   = 0;
  localparam int unsigned ST_RUN_BIT  = 1;
  localparam int unsigned CT_IE_BIT   = 0;
  localparam int unsigned CT_CONT_BIT = 1;
  localparam int unsigned CT_START_BIT = 2;
  localparam int unsigned CT_STOP_BIT = 3;

  typedef enum logic [1:0] {
    IDX_STATUS = 2'd0,
    IDX_CTRL   = 2'd1,
    IDX_RELOAD = 2'd2,
    IDX_SNAP   = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output reg_idx_e          idx_o,
  output logic              rd_o,
  output logic              wr_status_o,
  output logic              wr_ctrl_o,
  output logic              wr_reload_o
);
  localparam int unsigned MAP_MSB = 4;

  logic in_map;
  logic unused_lsb;

  assign unused_lsb = ^addr_i[1:0];

  generate
    if (ADDR_W > MAP_MSB) begin : g_upper
      assign in_map = (addr_i[ADDR_W-1:MAP_MSB] == '0);
    end else begin : g_flat
      assign in_map = 1'b1;
    end
  endgenerate

  assign idx_o       = reg_idx_e'(addr_i[3:2]);
  assign hit_o       = req_i && in_map;
  assign rd_o        = req_i && !we_i;
  assign wr_status_o = hit_o && we_i && (idx_o == IDX_STATUS);
  assign wr_ctrl_o   = hit_o && we_i && (idx_o == IDX_CTRL);
  assign wr_reload_o = hit_o && we_i && (idx_o == IDX_RELOAD);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             cont_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             expire;

  assign expire = run_q && (cnt_q <= CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (run_q) begin
      if (expire) begin
        if (cont_i) begin
          cnt_d = reload_i;
        end else begin
          cnt_d = '0;
          run_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
    if (load_i) cnt_d = load_val_i;
    if (stop_i) run_d = 1'b0;
    else if (start_i) run_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign run_o    = run_q;
  assign expire_o = expire;

  p_dec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q > CNT_W'(1) && !load_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  p_stop_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !run_q);

  p_reload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && cont_i && !load_i && !stop_i) |=> (run_q && cnt_q == $past(reload_i)));

  p_oneshot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !cont_i && !load_i && !start_i) |=> (!run_q && cnt_q == '0));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              rd_i,
  input  logic              hit_i,
  input  reg_idx_e          idx_i,
  input  logic              wr_status_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_reload_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_i,
  input  logic              run_i,
  input  logic [DATA_W-1:0] cnt_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] reload_o,
  output logic              to_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] ctrl_q, reload_q, rdata_q, rd_mux, status_w;
  logic              to_q, ack_q;

  always_comb begin
    status_w = '0;
    status_w[ST_TO_BIT]  = to_q;
    status_w[ST_RUN_BIT] = run_i;
  end

  always_comb begin
    unique case (idx_i)
      IDX_STATUS: rd_mux = status_w;
      IDX_CTRL:   rd_mux = ctrl_q;
      IDX_RELOAD: rd_mux = reload_q;
      default:    rd_mux = cnt_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      to_q     <= 1'b0;
      ack_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      ack_q   <= req_i;
      rdata_q <= (rd_i && hit_i) ? rd_mux : '0;
      if (wr_ctrl_i)   ctrl_q   <= wdata_i;
      if (wr_reload_i) reload_q <= wdata_i;
      // expiry beats a clearing write on the same edge
      if (expire_i)         to_q <= 1'b1;
      else if (wr_status_i) to_q <= 1'b0;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign to_o     = to_q;
  assign ack_o    = ack_q;
  assign rdata_o  = rdata_q;

  p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> to_q);

  p_flag_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_status_i && !expire_i) |=> !to_q);

  p_undef_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !hit_i) |=> (rdata_q == '0));

  p_ctrl_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl_i |=> $stable(ctrl_q));
endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  reg_idx_e          idx;
  logic              hit, rd, wr_status, wr_ctrl, wr_reload;
  logic [DATA_W-1:0] ctrl, reload, cnt;
  logic              run, expire, to_flag;

  tmr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .hit_o       (hit),
    .idx_o       (idx),
    .rd_o        (rd),
    .wr_status_o (wr_status),
    .wr_ctrl_o   (wr_ctrl),
    .wr_reload_o (wr_reload)
  );

  tmr_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_reload),
    .load_val_i (wdata_i),
    .start_i    (wr_ctrl && wdata_i[CT_START_BIT]),
    .stop_i     (wr_ctrl && wdata_i[CT_STOP_BIT]),
    .cont_i     (ctrl[CT_CONT_BIT]),
    .reload_i   (reload),
    .cnt_o      (cnt),
    .run_o      (run),
    .expire_o   (expire)
  );

  tmr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .rd_i        (rd),
    .hit_i       (hit),
    .idx_i       (idx),
    .wr_status_i (wr_status),
    .wr_ctrl_i   (wr_ctrl),
    .wr_reload_i (wr_reload),
    .wdata_i     (wdata_i),
    .expire_i    (expire),
    .run_i       (run),
    .cnt_i       (cnt),
    .ctrl_o      (ctrl),
    .reload_o    (reload),
    .to_o        (to_flag),
    .ack_o       (ack_o),
    .rdata_o     (rdata_o)
  );

  assign irq_o = to_flag && ctrl[CT_IE_BIT];

  p_irq_needs_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_status && !expire) |=> !irq_o);
endmodule

// File: tb/intv_timer_test.sv
`timescale 1ns/1ps
module intv_timer_test;
  localparam int DW = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ack, irq;
  logic [DW-1:0] rdata;

  int n_chk = 0, n_bad = 0;
  bit live = 0, done = 0;

  // reference state
  longint m_cnt, m_rel, m_ctrl;
  bit m_to, m_run, m_ack, m_irq;
  longint m_rd;

  always #2.5 clk = ~clk;

  intv_timer #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_rel = 0; m_ctrl = 0; m_to = 0; m_run = 0; m_ack = 0; m_rd = 0;
    end else begin
      bit fired;
      int widx;
      fired = 0;
      widx = int'(addr) / 4;
      m_ack = req;
      m_rd = 0;
      if (req && !we && addr < 16) begin
        case (widx)
          0: m_rd = (m_run ? 2 : 0) + (m_to ? 1 : 0);
          1: m_rd = m_ctrl;
          2: m_rd = m_rel;
          default: m_rd = m_cnt;
        endcase
      end
      if (m_run) begin
        if (m_cnt <= 1) begin
          fired = 1; m_to = 1;
          if (m_ctrl % 4 >= 2) m_cnt = m_rel;
          else begin m_cnt = 0; m_run = 0; end
        end else m_cnt = m_cnt - 1;
      end
      if (req && we && addr < 16) begin
        if (widx == 0 && !fired) m_to = 0;
        if (widx == 1) begin
          m_ctrl = longint'(wdata);
          if (wdata[2]) m_run = 1;
          if (wdata[3]) m_run = 0;
        end
        if (widx == 2) begin m_rel = longint'(wdata); m_cnt = longint'(wdata); end
      end
    end
    m_irq = m_to && (m_ctrl % 2 == 1);
  end

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && rst_n) begin
      chk("R1 ack cycle", longint'(ack), longint'(m_ack));
      chk("R1 read data", longint'(rdata), m_rd);
      chk("R10 irq level", longint'(irq), longint'(m_irq));
    end
  end

  task automatic wr(input int a, input longint d);
    req = 1; we = 1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input int a, output longint v);
    req = 1; we = 0; addr = AW'(a);
    @(negedge clk);
    req = 0;
    v = longint'(rdata);
  endtask

  task automatic rdc(input int a, input longint exp, input string tag);
    longint v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    longint snap, v;
    idle(3);
    rst_n = 1;
    idle(1);
    live = 1;
    // R13 reset state
    rdc('h0, 0, "R13 status after reset");
    rdc('h4, 0, "R13 ctrl after reset");
    rdc('h8, 0, "R13 reload after reset");
    rdc('hC, 0, "R13 count after reset");
    chk("R13 irq after reset", longint'(irq), 0);
    // R6 load, R1 offsets
    wr('h8, 5);
    rdc('hC, 5, "R6 reload loads count");
    rdc('h9, 5, "R1 low addr bits ignored");
    // one-shot with irq enable
    wr('h4, 'h5);
    rdc('h0, 'h2, "R2 running bit");
    idle(6);
    rdc('h0, 'h1, "R8 one-shot stops with flag");
    chk("R10 irq on flag and enable", longint'(irq), 1);
    rdc('hC, 0, "R8 count rests at zero");
    // R5 clear with any data
    wr('h0, 'hFFFF_FFFF);
    rdc('h0, 0, "R5 status write clears flag");
    chk("R5 irq dropped", longint'(irq), 0);
    // R9 continuous, irq masked
    wr('h8, 3);
    wr('h4, 'h6);
    idle(10);
    rdc('h0, 'h3, "R9 continuous keeps running");
    chk("R10 irq masked", longint'(irq), 0);
    // R4 stop wins
    wr('h4, 'hC);
    rdc('h0, 'h1, "R4 stop beats start");
    rdc('h4, 'hC, "R3 ctrl read back");
    wr('h4, 'hFFFF_FFF2);
    rdc('h4, 'hFFFF_FFF2, "R3 whole word stored");
    rdc('h0, 'h1, "R3 no start without bit 2");
    // R11 snapshot read-only
    wr('h0, 0);
    rd('hC, snap);
    wr('hC, 'h55);
    rdc('hC, snap, "R11 count write ignored");
    // R12 undefined offsets
    wr('h10, 'hFFFF);
    wr('h18, 'h4);
    rdc('h14, 0, "R12 undefined reads zero");
    rdc('h10, 0, "R12 undefined reads zero again");
    rdc('h8, 3, "R12 reload untouched");
    rdc('h0, 0, "R12 no start from undefined write");
    // R7 start at zero
    wr('h4, 0);
    wr('h8, 0);
    wr('h4, 'h4);
    rdc('h0, 'h2, "R7 running before zero expiry");
    rdc('h0, 'h1, "R7 zero count expires next cycle");
    // R5 expiry beats clear on the same edge
    wr('h0, 0);
    wr('h8, 2);
    wr('h4, 'h4);
    idle(1);
    wr('h0, 0);
    rdc('h0, 'h1, "R5 expiry wins over clear");
    // R6 load while running
    wr('h0, 0);
    wr('h8, 100);
    wr('h4, 'h4);
    idle(3);
    wr('h8, 7);
    rdc('hC, 7, "R6 load replaces running count");
    rd('hC, v);
    chk("R7 one step per cycle", v, 6);
    wr('h4, 'h8);
    // R13 reset mid-run
    wr('h8, 4);
    wr('h4, 'h7);
    idle(9);
    live = 0;
    rst_n = 0;
    idle(2);
    rst_n = 1;
    idle(1);
    live = 1;
    rdc('h0, 0, "R13 status after mid-run reset");
    rdc('h4, 0, "R13 ctrl after mid-run reset");
    rdc('hC, 0, "R13 count after mid-run reset");
    chk("R13 irq low after reset", longint'(irq), 0);
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule